// File: doc/BRIEF.md
# Parity-Protected SPI Register Master

This block is the controller side of a serial register link. A client presents one command at a time (read or write, a 6-bit register address and a 24-bit data word) with a valid/ready handshake. The block packs the command into a 32-bit frame and appends an odd-parity bit. It then drives the frame out most significant bit first in SPI mode 0, with chip select held low for the whole frame, and collects the 32-bit reply from the slave at the same time.

When the frame ends, the block splits the reply into an 8-bit status byte and a 24-bit register value. It checks odd parity over the whole reply and emits a one-cycle completion pulse. The results stay on the outputs until the next frame completes. A parameterised divider sets each SCLK half period as a whole number of system clocks. The same half period is used as the chip-select lead time before the first SCLK edge and as the hold time after the last one.

The sequencer has five states:
- `ST_IDLE` moves to `ST_LEAD` on an accepted command.
- `ST_LEAD` moves to `ST_SHIFT` on the first divider tick.
- `ST_SHIFT` moves to `ST_TRAIL` on the falling edge of the 32nd SCLK pulse.
- `ST_TRAIL` moves to `ST_GAP` on a tick. This is where chip select rises and done pulses.
- `ST_GAP` moves to `ST_IDLE` on a tick. This keeps chip select high for at least one half period between frames.

Top module: `spi_regmaster`

## Requirements
- R1: The transmitted frame carries the opcode in bit 31 (1 = write, 0 = read), the address in bits 30:25 and the data word in bits 24:1, sent bit 31 first. A read of address 0x01 with zero data gives 0x02000000.
- R2: Frame bit 0 makes the count of ones across all 32 bits odd. A write of 0x0003FF to 0x1B gives 0xB60007FE, and a write of 0 to 0x1C gives 0xB8000001.
- R3: SCLK idles low, and MOSI changes only when SCLK falls or chip select falls. MISO is captured on each SCLK rise.
- R4: Every frame has exactly 32 SCLK pulses, all with chip select low, and SCLK never goes high while chip select is high.
- R5: Chip select falls at least one half period before the first SCLK rise and rises at least one half period after the last SCLK fall. Done pulses in the same cycle that chip select rises.
- R6: The reply is split as follows: status = received bits 31:24 and read data = received bits 24:1. A reply of 0x00000040 yields status 0x00 and data 0x000020.
- R7: The parity-error output is 1 exactly when the 32 received bits hold an even number of ones.
- R8: A command is taken only while cmd_ready is high. A valid presented during a frame starts no frame and does not alter the frame in progress.
- R9: Done is high for exactly one cycle per frame. Status, data and parity-error hold their values between completions.
- R10: After synchronous reset, chip select is high, SCLK is low, cmd_ready is 1, busy is 0, done is 0 and the response outputs are 0.
- R11: Each SCLK high and low phase lasts exactly DIV_HALF system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 6 | Register address |
| cmd_wdata | input | 24 | Data field of the outgoing frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 8 | Status byte from the reply |
| rsp_rdata | output | 24 | Register value from the reply |
| rsp_parity_err | output | 1 | Reply failed the odd-parity check |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |

## Verification
The bench sweeps all 64 addresses with both opcodes and uses per-address data and reply words. It derives the expected frame and parity from the count of ones, so odd and even counts in both directions both occur. Fixed vectors pin down the exact bit positions of the opcode, the address offset and the trailing parity bit. A reply of 0x00000040 shows that the response is split with the status byte overlapping the shifted data field.

A frame with a valid held up during its middle separates a block that ignores the intruding command from one that restarts or corrupts the frame. Edge timing is measured at the pins for every frame to tell a correct mode-0 sequence from one with a lead, trail or half-period error.

// File: rtl/spi_regmaster_pkg.sv
package spi_regmaster_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_GAP
    } xfer_state_e;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_frame_pack.sv
module spi_frame_pack #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 24,
    localparam int FRAME_W = 2 + ADDR_W + DATA_W
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [FRAME_W-1:0] frame
);
    logic [FRAME_W-2:0] body;

    always_comb begin
        body  = {wr, addr, wdata};
        // odd parity: the appended bit is set when the body holds an even count
        frame = {body, ~(^body)};
    end
endmodule

// File: rtl/spi_frame_unpack.sv
module spi_frame_unpack #(
    parameter int DATA_W = 24,
    parameter int STAT_W = 8,
    parameter int FRAME_W = 32
) (
    input  logic [FRAME_W-1:0] rx,
    output logic [STAT_W-1:0]  status,
    output logic [DATA_W-1:0]  rdata,
    output logic               par_err
);
    always_comb begin
        status  = rx[FRAME_W-1 -: STAT_W];
        rdata   = rx[DATA_W:1];
        par_err = ~(^rx);
    end
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_regmaster_pkg::*;
#(
    parameter int DIV_HALF = 4,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 24,
    parameter int STAT_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [STAT_W-1:0] rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_parity_err,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int FRAME_W = 2 + ADDR_W + DATA_W;
    localparam int BIT_CW  = $clog2(FRAME_W);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(FRAME_W - 1);

    xfer_state_e state_q, state_d;

    logic               tick;
    logic [FRAME_W-1:0] tx_frame;
    logic [FRAME_W-1:0] tx_sh_q;
    logic [FRAME_W-1:0] rx_sh_q;
    logic [BIT_CW-1:0]  bit_q;
    logic               sclk_q;
    logic               cs_n_q;
    logic               done_q;
    logic [STAT_W-1:0]  stat_w, stat_q;
    logic [DATA_W-1:0]  rdat_w, rdat_q;
    logic               perr_w, perr_q;
    logic               accept;
    logic               final_fall;

    spi_half_tick #(.HALF_CYC(DIV_HALF)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q != ST_IDLE),
        .tick (tick)
    );

    spi_frame_pack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pack (
        .wr    (cmd_write),
        .addr  (cmd_addr),
        .wdata (cmd_wdata),
        .frame (tx_frame)
    );

    spi_frame_unpack #(.DATA_W(DATA_W), .STAT_W(STAT_W), .FRAME_W(FRAME_W)) u_unpack (
        .rx      (rx_sh_q),
        .status  (stat_w),
        .rdata   (rdat_w),
        .par_err (perr_w)
    );

    assign accept     = cmd_valid && (state_q == ST_IDLE);
    assign final_fall = tick && sclk_q && (bit_q == LAST_BIT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_valid)                        state_d = ST_LEAD;
            ST_LEAD:  if (tick)                             state_d = ST_SHIFT;
            ST_SHIFT: if (final_fall)                       state_d = ST_TRAIL;
            ST_TRAIL: if (tick)                             state_d = ST_GAP;
            ST_GAP:   if (tick)                             state_d = ST_IDLE;
            default:                                        state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and pin registers
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            bit_q   <= '0;
            sclk_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b0;
            stat_q  <= '0;
            rdat_q  <= '0;
            perr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        tx_sh_q <= tx_frame;
                        cs_n_q  <= 1'b0;
                        bit_q   <= '0;
                    end
                end
                ST_LEAD, ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q  <= 1'b1;
                            rx_sh_q <= {rx_sh_q[FRAME_W-2:0], spi_miso};
                        end else begin
                            sclk_q <= 1'b0;
                            if (bit_q != LAST_BIT) begin
                                tx_sh_q <= {tx_sh_q[FRAME_W-2:0], 1'b0};
                                bit_q   <= bit_q + 1'b1;
                            end
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        cs_n_q <= 1'b1;
                        done_q <= 1'b1;
                        stat_q <= stat_w;
                        rdat_q <= rdat_w;
                        perr_q <= perr_w;
                    end
                end
                ST_GAP: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign cmd_ready      = (state_q == ST_IDLE);
    assign busy           = (state_q != ST_IDLE);
    assign done           = done_q;
    assign rsp_status     = stat_q;
    assign rsp_rdata      = rdat_q;
    assign rsp_parity_err = perr_q;
    assign spi_sclk       = sclk_q;
    assign spi_cs_n       = cs_n_q;
    assign spi_mosi       = tx_sh_q[FRAME_W-1];

endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk #(
    parameter int DATA_W = 24,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              cmd_ready,
    input logic              spi_cs_n,
    input logic              spi_sclk,
    input logic              spi_mosi,
    input logic [STAT_W-1:0] rsp_status,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_parity_err
);
    p_idle_lines_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (spi_cs_n && !spi_sclk));

    p_sclk_needs_cs_r4: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !spi_cs_n);

    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |=> (!spi_sclk || $stable(spi_mosi)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (done || $stable({rsp_status, rsp_rdata, rsp_parity_err})));

    p_start_from_idle_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> $past(cmd_ready));

    p_done_at_cs_rise_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(spi_cs_n));
endmodule

bind spi_regmaster spi_regmaster_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .busy           (busy),
    .done           (done),
    .cmd_ready      (cmd_ready),
    .spi_cs_n       (spi_cs_n),
    .spi_sclk       (spi_sclk),
    .spi_mosi       (spi_mosi),
    .rsp_status     (rsp_status),
    .rsp_rdata      (rsp_rdata),
    .rsp_parity_err (rsp_parity_err)
);

// File: tb/tb_spi_regmaster.sv
module tb_spi_regmaster;
    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [5:0]  cmd_addr = '0;
    logic [23:0] cmd_wdata = '0;
    logic        spi_miso = 1'b0;
    logic        cmd_ready, busy, done, rsp_parity_err, spi_sclk, spi_cs_n, spi_mosi;
    logic [7:0]  rsp_status;
    logic [23:0] rsp_rdata;

    always #5 clk = ~clk;

    spi_regmaster #(.DIV_HALF(H)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .rsp_parity_err(rsp_parity_err), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- pin monitor and slave model ----------------
    int          cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [31:0] slave_resp = '0;
    logic [31:0] slave_sh = '0;
    logic [31:0] cap = '0;
    int          pulses = 0, frames = 0, lead = 0, trail = 0, half_bad = 0, mode_bad = 0;
    int          cs_fall_cyc = 0, last_edge = 0, last_fall = 0;
    logic        p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (p_cs && !spi_cs_n) begin
                frames++; pulses = 0; cap = '0; cs_fall_cyc = cyc;
                spi_miso = slave_resp[31]; slave_sh = slave_resp << 1;
            end
            if (!p_sclk && spi_sclk) begin
                cap = {cap[30:0], spi_mosi};
                if (pulses == 0) lead = cyc - cs_fall_cyc;
                else if (cyc - last_edge != H) half_bad++;
                pulses++; last_edge = cyc;
            end
            if (p_sclk && !spi_sclk) begin
                if (cyc - last_edge != H) half_bad++;
                last_edge = cyc; last_fall = cyc;
                spi_miso = slave_sh[31]; slave_sh = slave_sh << 1;
            end
            if (!p_cs && spi_cs_n) trail = cyc - last_fall;
            if (spi_sclk && spi_cs_n) mode_bad++;
            if (!spi_cs_n && (spi_mosi != p_mosi) && !(p_sclk && !spi_sclk) && !(p_cs && !spi_cs_n))
                mode_bad++;
        end
        p_sclk = spi_sclk; p_cs = spi_cs_n; p_mosi = spi_mosi;
    end

    function automatic logic [31:0] exp_frame(input logic w, input logic [5:0] a, input logic [23:0] d);
        logic [31:0] f;
        f = {w, a, d, 1'b0};
        f[0] = ($countones(f) % 2 == 0);
        return f;
    endfunction

    task automatic run_txn(input logic w, input logic [5:0] a, input logic [23:0] d,
                           input logic [31:0] resp, input bit intrude);
        int f0, hb0, mb0, guard;
        logic [31:0] ef;
        ef = exp_frame(w, a, d);
        slave_resp = resp;
        @(negedge clk);
        guard = 0;
        while (!cmd_ready && guard < 5000) begin @(negedge clk); guard++; end
        f0 = frames; hb0 = half_bad; mb0 = mode_bad;
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (intrude) begin
            repeat (10) @(negedge clk);
            cmd_valid = 1'b1; cmd_write = ~w; cmd_addr = ~a; cmd_wdata = ~d;
            repeat (30) @(negedge clk);
            cmd_valid = 1'b0;
        end
        guard = 0;
        while (!done && guard < 5000) begin @(negedge clk); guard++; end
        chk(done === 1'b1, "R9 done seen", {31'd0, done}, 32'd1);
        @(negedge clk);
        chk(done === 1'b0, "R9 done one cycle", {31'd0, done}, 32'd0);
        chk(cap === ef, "R1 R2 mosi frame", cap, ef);
        chk(pulses == 32, "R4 pulse count", pulses, 32);
        chk(lead >= H, "R5 cs lead", lead, H);
        chk(trail >= H, "R5 cs trail", trail, H);
        chk(half_bad == hb0, "R11 half period", half_bad - hb0, 0);
        chk(mode_bad == mb0, "R3 mode0 edges", mode_bad - mb0, 0);
        chk(rsp_status === resp[31:24], "R6 status", {24'd0, rsp_status}, {24'd0, resp[31:24]});
        chk(rsp_rdata === resp[24:1], "R6 rdata", {8'd0, rsp_rdata}, {8'd0, resp[24:1]});
        chk(rsp_parity_err === ($countones(resp) % 2 == 0), "R7 parity err",
            {31'd0, rsp_parity_err}, {31'd0, ($countones(resp) % 2 == 0)});
        if (intrude) begin
            repeat (4 * H + 6) @(negedge clk);
            chk(frames == f0 + 1, "R8 no extra frame", frames - f0, 1);
            chk(spi_cs_n === 1'b1, "R8 idle after ignored valid", {31'd0, spi_cs_n}, 32'd1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(spi_cs_n === 1'b1, "R10 cs high", {31'd0, spi_cs_n}, 1);
        chk(spi_sclk === 1'b0, "R10 sclk low", {31'd0, spi_sclk}, 0);
        chk(cmd_ready === 1'b1 && busy === 1'b0, "R10 ready", {30'd0, cmd_ready, busy}, 32'd2);
        chk(done === 1'b0, "R10 done low", {31'd0, done}, 0);
        chk({rsp_status, rsp_rdata, rsp_parity_err} === 33'd0, "R10 rsp zero",
            {rsp_status, rsp_rdata}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // fixed vectors: R1, R2, R6, R7
        run_txn(1'b0, 6'h01, 24'h000000, 32'h00000040, 1'b0);
        chk(exp_frame(1'b0, 6'h01, 24'h0) == 32'h02000000, "R1 id read vector", cap, 32'h02000000);
        chk(cap === 32'h02000000, "R1 id read frame", cap, 32'h02000000);
        chk(rsp_rdata === 24'h000020, "R6 id data", {8'd0, rsp_rdata}, 32'h20);
        chk(rsp_parity_err === 1'b0, "R7 id parity ok", {31'd0, rsp_parity_err}, 0);
        run_txn(1'b1, 6'h1B, 24'h0003FF, 32'hFFFFFFFF, 1'b0);
        chk(cap === 32'hB60007FE, "R2 write vector A", cap, 32'hB60007FE);
        chk(rsp_parity_err === 1'b1, "R7 all ones even", {31'd0, rsp_parity_err}, 1);
        run_txn(1'b1, 6'h1C, 24'h000000, 32'h80000000, 1'b0);
        chk(cap === 32'hB8000001, "R2 write vector B", cap, 32'hB8000001);

        // sweep all addresses, both opcodes
        for (int a = 0; a < 64; a++) begin
            for (int w = 0; w < 2; w++) begin
                logic [23:0] d;
                logic [31:0] r;
                d = (w == 1) ? 24'(a * 24'h0F1F3D ^ 24'hA5A5A5) : 24'h0;
                r = 32'(a * 32'h9E3779B9) ^ 32'(w * 32'h01234567);
                run_txn(w[0], a[5:0], d, r, 1'b0);
            end
        end

        // R8: valid held during a frame
        run_txn(1'b1, 6'h2A, 24'h5A5A5A, 32'h3C3C3C3D, 1'b1);

        // R9: outputs held while idle
        begin
            logic [32:0] snap;
            snap = {rsp_status, rsp_rdata, rsp_parity_err};
            repeat (40) @(negedge clk);
            chk({rsp_status, rsp_rdata, rsp_parity_err} === snap, "R9 outputs held",
                {rsp_status, rsp_rdata}, snap[32:1]);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule